// File: doc/BRIEF.md
# Channel Mask and Test-Pulse Injector

This block sits between a bank of discriminated wire signals and two downstream consumers, a timing path and a majority path. Each channel is forwarded to both paths through one output register unless a mask bit turns it off. A pattern register can inject pulses on chosen channels. These injected pulses are used to exercise the downstream logic without beam or cosmic activity.

Every setting is reached through an emulated JTAG data-register port. An external TAP controller presents its current state, the TMS level, a one-cycle strobe for each rising TCK edge, and the 4-bit instruction. From these the block decodes which data register is captured, shifted and updated. The pattern register has no update stage, so a new pattern takes effect while it is still being shifted. A pulse can therefore be fired from Pause-DR and the pattern then moved one step by returning to Shift-DR, which makes a walking-bit test cheap. A 4-bit control register picks the pulse source and chooses whether the injected pulse follows its source or is cut short.

Top module: `chmask_inject`

## Requirements
- R1: The instruction decodes as follows. Code 4'h0 selects the NCH-bit pattern register, 4'h1 the NCH-bit mask, 4'h2 the 4-bit control register and 4'h3 the 6-bit read-only location ID. Every other code, including 4'hF, selects a 1-bit bypass stage, which captures 0.
- R2: Data registers shift least significant bit first from `tdi_i`. `tdo_o` presents the bit that will leave on the next shift. A capture (state 4'h6) loads the current register value, a shift (state 4'h2) moves one bit per `tck_rise_i` strobe, and an update (state 4'h5) writes the mask or control register.
- R3: A mask bit of 1 forces that channel low on both `tmg_o` and `maj_o`, and a mask bit of 0 passes it. Both outputs follow the inputs one clock later.
- R4: The pattern register takes effect while it is being shifted, without an update. Source pulses fire only while the controller dwells in Run-Test/Idle (4'hC) or Pause-DR (4'h3) with `tms_i` low. Passing through either state with `tms_i` high fires nothing.
- R5: Control bits [1:0] select the pulse source: 01 is the TCK level, 10 is the external cable pulse, 11 is the readout-controller pulse, and 00 is none. Sources that are not selected have no effect.
- R6: Writing 100 into control bits [2:0] produces one pulse while the controller stays in Update-DR. Bit 2 clears once the controller is in any other state.
- R7: With control bit 3 clear, an injected pulse lasts at most TP_CUT clock cycles (default 5). With bit 3 set, it lasts as long as its source.
- R8: After reset the mask, pattern, control and ID registers are all zero, and both outputs are low.
- R9: An injected pattern bit is ORed with the live input of the same channel, and the mask also blocks injected bits.
- R10: The ID register is written only through `id_ld_i`/`id_val_i`. Shifting and updating through the port never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| live_i | input | NCH | Incoming wire signals |
| tap_state_i | input | 4 | Current TAP controller state code |
| tms_i | input | 1 | TMS level (0 means the controller stays in its state) |
| tck_rise_i | input | 1 | One-cycle strobe per rising TCK edge |
| ir_i | input | 4 | Current instruction |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out |
| tck_lvl_i | input | 1 | TCK level used as a pulse source |
| ext_pulse_i | input | 1 | External cable test pulse |
| roc_pulse_i | input | 1 | Readout-controller test pulse |
| id_ld_i | input | 1 | Parallel load strobe for the location ID |
| id_val_i | input | 6 | Location ID value |
| tmg_o | output | NCH | Gated channels toward the timing path |
| maj_o | output | NCH | Gated channels toward the majority path |

## Verification
The bench builds the block with its defaults: NCH = 96, a 6-bit ID and TP_CUT = 5. At these values a full 96-bit mask or pattern scan crosses every word of the shift path. A deliberate 8-bit shift through the 4-bit control register shows where the register length ends. The 5-cycle cut is short enough to watch the pulse end, both from a held external source and from the instruction pulse in Update-DR. A random phase mixes dwelling and passing states, TMS values and all three pulse sources over fixed mask and pattern values.

// File: rtl/chmask_pkg.sv
package chmask_pkg;
  localparam logic [3:0] ST_IDLE    = 4'hC;
  localparam logic [3:0] ST_CAPTURE = 4'h6;
  localparam logic [3:0] ST_SHIFT   = 4'h2;
  localparam logic [3:0] ST_PAUSE   = 4'h3;
  localparam logic [3:0] ST_UPDATE  = 4'h5;

  localparam logic [3:0] IR_PAT  = 4'h0;
  localparam logic [3:0] IR_MASK = 4'h1;
  localparam logic [3:0] IR_CTRL = 4'h2;
  localparam logic [3:0] IR_ID   = 4'h3;

  localparam int CTRL_W = 4;

  // Scan length of the register an instruction selects.
  function automatic int dr_len(input logic [3:0] ir, input int nch, input int idw);
    case (ir)
      IR_PAT, IR_MASK: return nch;
      IR_CTRL:         return CTRL_W;
      IR_ID:           return idw;
      default:         return 1;
    endcase
  endfunction
endpackage

// File: rtl/chmask_dr.sv
module chmask_dr
  import chmask_pkg::*;
#(
  parameter int NCH = 96,
  parameter int IDW = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        ir_i,
  input  logic [3:0]        state_i,
  input  logic              tck_rise_i,
  input  logic              tdi_i,
  input  logic              id_ld_i,
  input  logic [IDW-1:0]    id_val_i,
  output logic              tdo_o,
  output logic [NCH-1:0]    mask_o,
  output logic [NCH-1:0]    pat_o,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [NCH-1:0]    sh_q, sh_n, sh_up, cap_v;
  logic [NCH-1:0]    pat_q, mask_q;
  logic [CTRL_W-1:0] ctrl_q;
  logic [IDW-1:0]    id_q;
  int                len;

  assign len   = dr_len(ir_i, NCH, IDW);
  assign sh_up = {1'b0, sh_q[NCH-1:1]};

  // Shift with the entry point at the selected register's top bit.
  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      if (i == len - 1)     sh_n[i] = tdi_i;
      else if (i < len - 1) sh_n[i] = sh_up[i];
      else                  sh_n[i] = sh_q[i];
    end
  end

  always_comb begin
    cap_v = '0;
    case (ir_i)
      IR_MASK: cap_v = mask_q;
      IR_CTRL: cap_v[CTRL_W-1:0] = ctrl_q;
      IR_ID:   cap_v[IDW-1:0] = id_q;
      default: cap_v = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q   <= '0;
      pat_q  <= '0;
      mask_q <= '0;
      ctrl_q <= '0;
      id_q   <= '0;
    end else begin
      if (id_ld_i) id_q <= id_val_i;
      if (ctrl_q[2] && state_i != ST_UPDATE) ctrl_q[2] <= 1'b0;
      if (tck_rise_i) begin
        case (state_i)
          ST_CAPTURE: sh_q <= cap_v;
          ST_SHIFT: begin
            if (ir_i == IR_PAT) pat_q <= {tdi_i, pat_q[NCH-1:1]};
            else                sh_q  <= sh_n;
          end
          ST_UPDATE: begin
            if (ir_i == IR_MASK) mask_q <= sh_q;
            if (ir_i == IR_CTRL) ctrl_q <= sh_q[CTRL_W-1:0];
          end
          default: ;
        endcase
      end
    end
  end

  assign tdo_o  = (ir_i == IR_PAT) ? pat_q[0] : sh_q[0];
  assign mask_o = mask_q;
  assign pat_o  = pat_q;
  assign ctrl_o = ctrl_q;

  // R6: the instruction-pulse bit does not survive outside Update-DR
  p_bit2_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[2] && state_i != ST_UPDATE) |=> !ctrl_q[2]);

  // R10: port activity leaves the ID register alone
  p_id_readonly_r10: assert property (@(posedge clk) disable iff (rst)
    (!id_ld_i) |=> $stable(id_q));

  // R4: the pattern moves only on a shift strobe while selected
  p_pat_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !(tck_rise_i && state_i == ST_SHIFT && ir_i == IR_PAT) |=> $stable(pat_q));
endmodule

// File: rtl/chmask_pulse.sv
module chmask_pulse
  import chmask_pkg::*;
#(
  parameter int TP_CUT = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CTRL_W-1:0] ctrl_i,
  input  logic [3:0]        state_i,
  input  logic              tms_i,
  input  logic              tck_lvl_i,
  input  logic              ext_i,
  input  logic              roc_i,
  output logic              tp_o
);
  localparam int AW = $clog2(TP_CUT + 1);

  logic          dwell, src;
  logic [AW-1:0] age_q;

  assign dwell = !tms_i && (state_i == ST_IDLE || state_i == ST_PAUSE);

  always_comb begin
    case (ctrl_i[1:0])
      2'b01:   src = tck_lvl_i && dwell;
      2'b10:   src = ext_i && dwell;
      2'b11:   src = roc_i && dwell;
      default: src = ctrl_i[2] && (state_i == ST_UPDATE);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || !src)             age_q <= '0;
    else if (age_q != AW'(TP_CUT)) age_q <= age_q + 1'b1;
  end

  assign tp_o = src && (ctrl_i[3] || age_q < AW'(TP_CUT));

  // Checker: consecutive cut-mode pulse cycles
  logic [AW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst || !tp_o || ctrl_i[3]) run_q <= '0;
    else if (run_q != AW'(TP_CUT)) run_q <= run_q + 1'b1;
  end

  // R7: a cut pulse never exceeds TP_CUT cycles
  p_cut_len_r7: assert property (@(posedge clk) disable iff (rst)
    (tp_o && !ctrl_i[3]) |-> (run_q < AW'(TP_CUT)));

  // R4: no pulse outside a dwell or the Update-DR instruction pulse
  p_window_r4: assert property (@(posedge clk) disable iff (rst)
    tp_o |-> ((!tms_i && (state_i == ST_IDLE || state_i == ST_PAUSE)) || state_i == ST_UPDATE));
endmodule

// File: rtl/chmask_gate.sv
module chmask_gate #(
  parameter int NCH = 96
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] live_i,
  input  logic [NCH-1:0] mask_i,
  input  logic [NCH-1:0] pat_i,
  input  logic           tp_i,
  output logic [NCH-1:0] tmg_o,
  output logic [NCH-1:0] maj_o
);
  logic [NCH-1:0] pass;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign pass[c] = !mask_i[c] && (live_i[c] || (pat_i[c] && tp_i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tmg_o <= '0;
      maj_o <= '0;
    end else begin
      tmg_o <= pass;
      maj_o <= pass;
    end
  end

  // R3 / R9: a masked channel stays low on both paths
  p_mask_blocks_r3: assert property (@(posedge clk) disable iff (rst)
    (mask_i != '0) |=> (((tmg_o | maj_o) & $past(mask_i)) == '0));

  // R3: an unmasked live hit reaches both paths one cycle later
  p_live_pass_r3: assert property (@(posedge clk) disable iff (rst)
    ((live_i & ~mask_i) != '0) |=> (((tmg_o & maj_o) & $past(live_i & ~mask_i)) == $past(live_i & ~mask_i)));
endmodule

// File: rtl/chmask_inject.sv
module chmask_inject
  import chmask_pkg::*;
#(
  parameter int NCH    = 96,
  parameter int IDW    = 6,
  parameter int TP_CUT = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] live_i,
  input  logic [3:0]     tap_state_i,
  input  logic           tms_i,
  input  logic           tck_rise_i,
  input  logic [3:0]     ir_i,
  input  logic           tdi_i,
  output logic           tdo_o,
  input  logic           tck_lvl_i,
  input  logic           ext_pulse_i,
  input  logic           roc_pulse_i,
  input  logic           id_ld_i,
  input  logic [IDW-1:0] id_val_i,
  output logic [NCH-1:0] tmg_o,
  output logic [NCH-1:0] maj_o
);
  logic [NCH-1:0]    mask, pat;
  logic [CTRL_W-1:0] ctrl;
  logic              tp;

  chmask_dr #(.NCH(NCH), .IDW(IDW)) u_dr (
    .clk(clk), .rst(rst), .ir_i(ir_i), .state_i(tap_state_i),
    .tck_rise_i(tck_rise_i), .tdi_i(tdi_i), .id_ld_i(id_ld_i),
    .id_val_i(id_val_i), .tdo_o(tdo_o), .mask_o(mask), .pat_o(pat),
    .ctrl_o(ctrl)
  );

  chmask_pulse #(.TP_CUT(TP_CUT)) u_pulse (
    .clk(clk), .rst(rst), .ctrl_i(ctrl), .state_i(tap_state_i),
    .tms_i(tms_i), .tck_lvl_i(tck_lvl_i), .ext_i(ext_pulse_i),
    .roc_i(roc_pulse_i), .tp_o(tp)
  );

  chmask_gate #(.NCH(NCH)) u_gate (
    .clk(clk), .rst(rst), .live_i(live_i), .mask_i(mask), .pat_i(pat),
    .tp_i(tp), .tmg_o(tmg_o), .maj_o(maj_o)
  );
endmodule

// File: tb/sim_chmask_inject.sv
module sim_chmask_inject;
  localparam logic [3:0] S_IDLE = 4'hC, S_CAP = 4'h6, S_SHIFT = 4'h2,
                         S_PAUSE = 4'h3, S_UPD = 4'h5;

  logic        clk = 1'b0, rst = 1'b1;
  logic [95:0] live_i = '0;
  logic [3:0]  tap_state_i = S_IDLE, ir_i = 4'hF;
  logic        tms_i = 1'b1, tck_rise_i = 1'b0, tdi_i = 1'b0;
  logic        tck_lvl_i = 1'b0, ext_pulse_i = 1'b0, roc_pulse_i = 1'b0;
  logic        id_ld_i = 1'b0;
  logic [5:0]  id_val_i = '0;
  logic        tdo_o;
  logic [95:0] tmg_o, maj_o;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chmask_inject u0 (
    .clk(clk), .rst(rst), .live_i(live_i), .tap_state_i(tap_state_i),
    .tms_i(tms_i), .tck_rise_i(tck_rise_i), .ir_i(ir_i), .tdi_i(tdi_i),
    .tdo_o(tdo_o), .tck_lvl_i(tck_lvl_i), .ext_pulse_i(ext_pulse_i),
    .roc_pulse_i(roc_pulse_i), .id_ld_i(id_ld_i), .id_val_i(id_val_i),
    .tmg_o(tmg_o), .maj_o(maj_o)
  );

  function automatic logic [95:0] f_exp(input logic [95:0] live, input logic [95:0] msk,
                                        input logic [95:0] pat, input logic tp);
    return ~msk & (live | (pat & {96{tp}}));
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [95:0] exp);
    chk(req, {32'h0, tmg_o}, {32'h0, exp});
    chk(req, {32'h0, maj_o}, {32'h0, exp});
  endtask

  task automatic scan(input logic [3:0] ir, input logic [127:0] din, input int len,
                      input bit upd, output logic [127:0] dout);
    dout = '0;
    ir_i = ir; tms_i = 1'b1; tap_state_i = S_CAP; tck_rise_i = 1'b1;
    @(negedge clk);
    tap_state_i = S_SHIFT;
    for (int i = 0; i < len; i++) begin
      dout[i] = tdo_o;
      tdi_i = din[i];
      @(negedge clk);
    end
    if (upd) begin
      tap_state_i = S_UPD;
      @(negedge clk);
    end
    tck_rise_i = 1'b0;
    tap_state_i = upd ? S_IDLE : S_PAUSE;
    @(negedge clk);
  endtask

  function automatic logic [95:0] r96();
    return {$urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [127:0] rd;
    logic [95:0]  m, p, q, lv;
    logic [1:0]   sel;
    logic         tpx;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R8: reset state
    chk_out("R8 outputs after reset", '0);
    scan(4'h1, '0, 96, 1'b1, rd);  chk("R8 mask reset", rd, '0);
    scan(4'h2, '0, 4, 1'b1, rd);   chk("R8 ctrl reset", rd, '0);
    scan(4'h3, '0, 6, 1'b1, rd);   chk("R8 id reset", rd, '0);
    scan(4'h0, '0, 96, 1'b0, rd);  chk("R8 pattern reset", rd, '0);

    // R1: bypass for undefined codes, register lengths
    scan(4'hF, 128'h1, 2, 1'b1, rd); chk("R1 bypass 4'hF", rd, 128'h2);
    scan(4'h7, 128'h1, 2, 1'b1, rd); chk("R1 bypass 4'h7", rd, 128'h2);
    scan(4'h2, 128'h6B, 8, 1'b0, rd); chk("R1 ctrl length 4", rd, 128'hB0);

    // R3: mask gating on random live traffic
    m = r96();
    scan(4'h1, {32'h0, m}, 96, 1'b1, rd);
    scan(4'h1, {32'h0, m}, 96, 1'b1, rd);
    chk("R2 mask readback LSB first", rd, {32'h0, m});
    tap_state_i = S_IDLE; tms_i = 1'b1;
    for (int k = 0; k < 20; k++) begin
      lv = r96(); live_i = lv;
      @(negedge clk);
      chk_out("R3 mask gating", f_exp(lv, m, '0, 1'b0));
    end
    live_i = '0;

    // R4/R9: pattern active without update, pulse only while dwelling
    scan(4'h2, 128'hA, 4, 1'b1, rd);      // bit3=1, external source
    p = r96();
    scan(4'h0, {32'h0, p}, 96, 1'b0, rd); // stays in Pause-DR, tms high
    ext_pulse_i = 1'b1;
    @(negedge clk);
    chk_out("R4 passing Pause-DR fires nothing", '0);
    tms_i = 1'b0;
    @(negedge clk);
    chk_out("R4 dwell in Pause-DR fires pattern", f_exp('0, m, p, 1'b1));
    lv = r96(); live_i = lv;
    @(negedge clk);
    chk_out("R9 pattern ORed with live under mask", f_exp(lv, m, p, 1'b1));
    ext_pulse_i = 1'b0; live_i = '0; tms_i = 1'b1;
    @(negedge clk);
    q = r96();
    scan(4'h0, {32'h0, q}, 96, 1'b0, rd);
    chk("R4 pattern shifted without update", rd, {32'h0, p});
    p = q;

    // R5: source selection
    scan(4'h2, 128'h9, 4, 1'b1, rd);      // TCK level
    tap_state_i = S_IDLE; tms_i = 1'b0; tck_lvl_i = 1'b1;
    @(negedge clk);
    chk_out("R5 TCK source", f_exp('0, m, p, 1'b1));
    tck_lvl_i = 1'b0; tms_i = 1'b1;
    @(negedge clk);
    scan(4'h2, 128'hB, 4, 1'b1, rd);      // readout source
    tms_i = 1'b0; ext_pulse_i = 1'b1;
    @(negedge clk);
    chk_out("R5 unselected source ignored", '0);
    ext_pulse_i = 1'b0; roc_pulse_i = 1'b1;
    @(negedge clk);
    chk_out("R5 readout source", f_exp('0, m, p, 1'b1));
    roc_pulse_i = 1'b0; tms_i = 1'b1;
    @(negedge clk);

    // R7: width cut versus full width
    scan(4'h2, 128'h2, 4, 1'b1, rd);
    tms_i = 1'b0; ext_pulse_i = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk_out("R7 cut to 5 cycles", (k <= 5) ? f_exp('0, m, p, 1'b1) : '0);
    end
    ext_pulse_i = 1'b0; tms_i = 1'b1;
    @(negedge clk);
    scan(4'h2, 128'hA, 4, 1'b1, rd);
    tms_i = 1'b0; ext_pulse_i = 1'b1;
    for (int k = 1; k <= 8; k++) begin
      @(negedge clk);
      chk_out("R7 full width with bit 3", f_exp('0, m, p, 1'b1));
    end
    ext_pulse_i = 1'b0; tms_i = 1'b1;
    @(negedge clk);

    // R6: instruction pulse in Update-DR, then bit 2 clears
    scan(4'h2, 128'h4, 4, 1'b0, rd);
    tap_state_i = S_UPD; tck_rise_i = 1'b1;
    @(negedge clk);
    tck_rise_i = 1'b0;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      chk_out("R6 pulse in Update-DR", (k <= 5) ? f_exp('0, m, p, 1'b1) : '0);
    end
    tap_state_i = S_IDLE; tms_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk_out("R6 no pulse after leaving Update-DR", '0);
    scan(4'h2, '0, 4, 1'b1, rd);
    chk("R6 bit 2 self-cleared", rd, '0);

    // R10: ID parallel load, read-only through the port
    id_val_i = 6'h2D; id_ld_i = 1'b1;
    @(negedge clk);
    id_ld_i = 1'b0;
    scan(4'h3, 128'h12, 6, 1'b1, rd); chk("R10 id readback", rd, 128'h2D);
    scan(4'h3, '0, 6, 1'b1, rd);      chk("R10 id unchanged by shift", rd, 128'h2D);

    // Random phase: sources, states and tms mixed, full-width pulses
    for (int blk = 0; blk < 4; blk++) begin
      sel = 2'(($urandom() % 3) + 1);
      scan(4'h2, {124'h0, 2'b10, sel}, 4, 1'b1, rd);
      for (int k = 0; k < 40; k++) begin
        logic [3:0] st;
        logic tm, a, b, c;
        case ($urandom() % 4)
          0: st = S_IDLE;
          1: st = S_PAUSE;
          2: st = S_SHIFT;
          default: st = S_CAP;
        endcase
        tm = 1'($urandom()); a = 1'($urandom()); b = 1'($urandom()); c = 1'($urandom());
        lv = r96() & r96();
        tap_state_i = st; tms_i = tm; tck_lvl_i = a; ext_pulse_i = b; roc_pulse_i = c;
        live_i = lv;
        tpx = (!tm && (st == S_IDLE || st == S_PAUSE)) &&
              ((sel == 2'b01) ? a : (sel == 2'b10) ? b : c);
        @(negedge clk);
        chk_out("R5 R4 random source and window", f_exp(lv, m, p, tpx));
      end
      tap_state_i = S_IDLE; tms_i = 1'b1; live_i = '0;
      tck_lvl_i = 1'b0; ext_pulse_i = 1'b0; roc_pulse_i = 1'b0;
      @(negedge clk);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule